// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Write Sequencer

This block sits on the host side of a 16-bit pseudo-SRAM that is run in its asynchronous mode. It takes one write request at a time and turns it into a single write cycle on the memory pins. Each request carries a 21-bit word address, a 16-bit data word and two byte enables. The block drives the active-low chip select, write enable, upper and lower byte strobes and address-valid strobe. It also drives the address bus, plus the data value and the output-enable that control the data pads.

A write moves through four phases. In the setup phase the address is presented and chip select goes low. In the pulse phase write enable and the selected byte strobes go low. In the hold phase data stays on the bus after the first strobe has risen. In the recovery phase all strobes are idle. The length of each phase is a number of clock cycles taken from parameters. A parameter chooses which strobe ends the write: write enable in one style, chip select in the other. A per-request mode bit chooses whether the address-valid strobe gives one short latch pulse or stays low for the whole cycle.

Top module: `psw_write_ctrl`

## Requirements
- R1: `req_ready` is high only when no cycle is in progress. A request is taken only on a clock edge where both `req_valid` and `req_ready` are high. While a cycle runs, new requests do not change the address or the data.
- R2: On the first cycle after the accepting edge, the setup phase starts. It lasts SU = max(T_ADDR_SETUP, T_ADV_LOW) cycles, with `mem_cs_n`=0, `mem_we_n`=1 and both byte strobes at 1.
- R3: The pulse phase follows. It lasts PL = max(T_WE_LOW, T_DATA_SETUP+1) cycles, with `mem_cs_n`=0 and `mem_we_n`=0. `mem_ub_n` (data bits 15:8) is low exactly when `req_be[1]`=1, and `mem_lb_n` (bits 7:0) is low exactly when `req_be[0]`=1. The byte strobes stay low through the hold phase.
- R4: A request with `req_be`=2'b00 starts no cycle. Every strobe stays high, `req_ready` stays high and `done` stays low.
- R5: `mem_dq_oe` is 0 on the first pulse cycle. It is 1 from the second pulse cycle through the end of the hold phase, and 0 otherwise. While it is 1, `mem_dq_out` equals the request data. `mem_addr` equals the request address for the whole cycle.
- R6: With TERM_CS=0, the hold phase lasts T_DATA_HOLD cycles with `mem_we_n`=1 while `mem_cs_n`=0. Write enable is therefore the first strobe to rise.
- R7: With TERM_CS=1, the hold phase lasts T_DATA_HOLD cycles with `mem_cs_n`=1 while `mem_we_n`=0. Chip select is therefore the first strobe to rise.
- R8: With `adv_hold`=0 at acceptance, `mem_adv_n` is low for the first T_ADV_LOW setup cycles and high for the rest of the cycle.
- R9: With `adv_hold`=1 at acceptance, `mem_adv_n` is low from the first setup cycle through the last recovery cycle.
- R10: The recovery phase lasts T_RECOVER cycles with all strobes high and `mem_dq_oe`=0. `done` is high for exactly its last cycle, and `req_ready` is high on the next cycle.
- R11: A clock edge with `rst`=1 sets all five strobes to 1, `mem_dq_oe` to 0, `done` to 0 and `req_ready` to 1, even in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Write request present |
| req_addr | input | 21 | Word address of the request |
| req_data | input | 16 | Data word of the request |
| req_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| adv_hold | input | 1 | 1: address-valid stays low all cycle; 0: short latch pulse |
| req_ready | output | 1 | Idle and able to take a request |
| done | output | 1 | One-cycle pulse on the last recovery cycle |
| mem_addr | output | 21 | Memory address bus |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_dq_out | output | 16 | Value to drive on the data pads |
| mem_dq_oe | output | 1 | Data pad output enable (0 = high impedance) |

## Verification
All pins are registered from the next-state values, so a wrong phase or a wrong count shows at the pins on the very next cycle. It appears as a strobe edge one cycle early or late, an output enable that overlaps the wrong phase, or a `done` pulse in the wrong place. A bad capture register shows as the wrong address or data during the same cycle. The bench compares every pin on every cycle of each write against a schedule it computes from the phase lengths. It runs two instances, one for each termination style, so an error in the ordering of the rising edges is caught on the first hold cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_PULSE = 3'd2,
        PH_HOLD  = 3'd3,
        PH_RECOV = 3'd4
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic ub_n;
        logic lb_n;
        logic adv_n;
        logic oe;
        logic done;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, we_n: 1'b1, ub_n: 1'b1,
                                   lb_n: 1'b1, adv_n: 1'b1, oe: 1'b0,
                                   done: 1'b0};

endpackage

// File: rtl/psw_phase_timer.sv
module psw_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_nx,
    output logic             last
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_nx = cnt_d;
    assign last   = (cnt_q == '0);

endmodule

// File: rtl/psw_pin_encoder.sv
module psw_pin_encoder
    import psw_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int SETUP_LEN = 2,
    parameter int ADV_LEN   = 1,
    parameter int PULSE_LEN = 3,
    parameter bit TERM_CS   = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase_nx,
    input  logic [CNT_W-1:0] cnt_nx,
    input  logic [1:0]       be_nx,
    input  logic             hold_nx,
    output pins_t            pins
);

    localparam logic [CNT_W-1:0] ADV_EDGE   = CNT_W'(SETUP_LEN - ADV_LEN);
    localparam logic [CNT_W-1:0] PULSE_HEAD = CNT_W'(PULSE_LEN - 1);

    pins_t pins_d, pins_q;
    logic  in_pulse, in_hold, in_setup, busy;

    always_comb begin
        in_setup = (phase_nx == PH_SETUP);
        in_pulse = (phase_nx == PH_PULSE);
        in_hold  = (phase_nx == PH_HOLD);
        busy     = (phase_nx != PH_IDLE);

        pins_d = PINS_IDLE;
        if (TERM_CS) begin
            pins_d.cs_n = !(in_setup || in_pulse);
            pins_d.we_n = !(in_pulse || in_hold);
        end else begin
            pins_d.cs_n = !(in_setup || in_pulse || in_hold);
            pins_d.we_n = !in_pulse;
        end
        pins_d.ub_n  = !((in_pulse || in_hold) && be_nx[1]);
        pins_d.lb_n  = !((in_pulse || in_hold) && be_nx[0]);
        pins_d.adv_n = !((hold_nx && busy) ||
                         (!hold_nx && in_setup && (cnt_nx >= ADV_EDGE)));
        pins_d.oe    = (in_pulse && (cnt_nx != PULSE_HEAD)) || in_hold;
        pins_d.done  = (phase_nx == PH_RECOV) && (cnt_nx == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q <= PINS_IDLE;
        end else begin
            pins_q <= pins_d;
        end
    end

    assign pins = pins_q;

endmodule

// File: rtl/psw_write_ctrl.sv
module psw_write_ctrl
    import psw_pkg::*;
#(
    parameter int ADDR_W        = 21,
    parameter int DATA_W        = 16,
    parameter int T_ADDR_SETUP  = 2,
    parameter int T_ADV_LOW     = 1,
    parameter int T_WE_LOW      = 3,
    parameter int T_DATA_SETUP  = 2,
    parameter int T_DATA_HOLD   = 1,
    parameter int T_RECOVER     = 2,
    parameter bit TERM_CS       = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [1:0]        req_be,
    input  logic              adv_hold,
    output logic              req_ready,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_adv_n,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);

    localparam int SETUP_LEN = (T_ADDR_SETUP > T_ADV_LOW) ? T_ADDR_SETUP : T_ADV_LOW;
    localparam int PULSE_LEN = (T_WE_LOW > T_DATA_SETUP + 1) ? T_WE_LOW : T_DATA_SETUP + 1;
    localparam int MAX_AB    = (SETUP_LEN > PULSE_LEN) ? SETUP_LEN : PULSE_LEN;
    localparam int MAX_CD    = (T_DATA_HOLD > T_RECOVER) ? T_DATA_HOLD : T_RECOVER;
    localparam int MAX_LEN   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [1:0]        be;
        logic              hold;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             t_load, t_last;
    logic [CNT_W-1:0] t_load_val, t_cnt_nx;
    logic             take;
    pins_t            pins;

    assign req_ready = (ctl_q.phase == PH_IDLE);
    assign take      = req_valid && req_ready && (req_be != 2'b00);

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (take) begin
                    ctl_d.phase = PH_SETUP;
                    ctl_d.addr  = req_addr;
                    ctl_d.data  = req_data;
                    ctl_d.be    = req_be;
                    ctl_d.hold  = adv_hold;
                end
            end
            PH_SETUP: if (t_last) ctl_d.phase = PH_PULSE;
            PH_PULSE: if (t_last) ctl_d.phase = PH_HOLD;
            PH_HOLD:  if (t_last) ctl_d.phase = PH_RECOV;
            PH_RECOV: if (t_last) ctl_d.phase = PH_IDLE;
            default:  ctl_d.phase = PH_IDLE;
        endcase

        t_load = (ctl_d.phase != ctl_q.phase);
        unique case (ctl_d.phase)
            PH_SETUP: t_load_val = CNT_W'(SETUP_LEN - 1);
            PH_PULSE: t_load_val = CNT_W'(PULSE_LEN - 1);
            PH_HOLD:  t_load_val = CNT_W'(T_DATA_HOLD - 1);
            PH_RECOV: t_load_val = CNT_W'(T_RECOVER - 1);
            default:  t_load_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{phase: PH_IDLE, addr: '0, data: '0, be: 2'b00, hold: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    psw_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_load_val),
        .cnt_nx   (t_cnt_nx),
        .last     (t_last)
    );

    psw_pin_encoder #(
        .CNT_W     (CNT_W),
        .SETUP_LEN (SETUP_LEN),
        .ADV_LEN   (T_ADV_LOW),
        .PULSE_LEN (PULSE_LEN),
        .TERM_CS   (TERM_CS)
    ) u_pins (
        .clk      (clk),
        .rst      (rst),
        .phase_nx (ctl_d.phase),
        .cnt_nx   (t_cnt_nx),
        .be_nx    (ctl_d.be),
        .hold_nx  (ctl_d.hold),
        .pins     (pins)
    );

    assign mem_addr   = ctl_q.addr;
    assign mem_dq_out = ctl_q.data;
    assign mem_cs_n   = pins.cs_n;
    assign mem_we_n   = pins.we_n;
    assign mem_ub_n   = pins.ub_n;
    assign mem_lb_n   = pins.lb_n;
    assign mem_adv_n  = pins.adv_n;
    assign mem_dq_oe  = pins.oe;
    assign done       = pins.done;

endmodule

// File: rtl/psw_write_checker.sv
module psw_write_checker #(
    parameter int ADDR_W  = 21,
    parameter int DATA_W  = 16,
    parameter bit TERM_CS = 1'b0
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_be,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_adv_n,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_ub_n,
    input logic              mem_lb_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_cs_n && mem_we_n && mem_ub_n && mem_lb_n && mem_adv_n && !mem_dq_oe));

    a_r1_addr_kept: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !$past(req_ready)) |-> $stable(mem_addr));

    a_r2_setup_we_high: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cs_n) |-> (mem_we_n && mem_ub_n && mem_lb_n));

    a_r3_bytes_in_cycle: assert property (@(posedge clk) disable iff (rst)
        (!mem_ub_n || !mem_lb_n) |-> (!mem_cs_n || !mem_we_n));

    a_r4_empty_ignored: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_be == 2'b00) |=> req_ready);

    a_r5_oe_after_we: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_dq_oe) |-> (!$past(mem_we_n) && !mem_we_n));

    a_r5_data_steady: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    a_r6_we_rises_first: assert property (@(posedge clk) disable iff (rst)
        (!TERM_CS && $rose(mem_we_n)) |-> (!mem_cs_n && mem_dq_oe));

    a_r7_cs_rises_first: assert property (@(posedge clk) disable iff (rst)
        (TERM_CS && $rose(mem_cs_n)) |-> (!mem_we_n && mem_dq_oe));

    a_r10_done_then_ready: assert property (@(posedge clk) disable iff (rst)
        done |=> req_ready);

    a_r11_reset_idle: assert property (@(posedge clk)
        rst |=> (mem_cs_n && mem_we_n && mem_ub_n && mem_lb_n && mem_adv_n
                 && !mem_dq_oe && !done && req_ready));

endmodule

bind psw_write_ctrl psw_write_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .TERM_CS (TERM_CS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_be     (req_be),
    .req_ready  (req_ready),
    .done       (done),
    .mem_addr   (mem_addr),
    .mem_adv_n  (mem_adv_n),
    .mem_cs_n   (mem_cs_n),
    .mem_we_n   (mem_we_n),
    .mem_ub_n   (mem_ub_n),
    .mem_lb_n   (mem_lb_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sim_psw_write_ctrl.sv
`timescale 1ns/1ps
module sim_psw_write_ctrl;

    localparam int T_AS = 2, T_VP = 1, T_WP = 3, T_DS = 2, T_DH = 1, T_WR = 2;
    localparam int SU = (T_AS > T_VP) ? T_AS : T_VP;
    localparam int PL = (T_WP > T_DS + 1) ? T_WP : T_DS + 1;
    localparam int N  = SU + PL + T_DH + T_WR;
    localparam int NV = 6;

    // fields: addr[40:20] data[19:4] be[3:2] hold[1] poke[0]
    localparam logic [40:0] VECS [NV] = '{
        {21'h1A_BCDE, 16'hBEEF, 2'b11, 1'b0, 1'b0},
        {21'h00_0001, 16'h1234, 2'b10, 1'b1, 1'b0},
        {21'h1F_FFFF, 16'hA55A, 2'b01, 1'b0, 1'b1},
        {21'h0C_0C0C, 16'h0000, 2'b11, 1'b1, 1'b1},
        {21'h15_5555, 16'hFFFF, 2'b01, 1'b1, 1'b0},
        {21'h0A_AAAA, 16'h8001, 2'b10, 1'b0, 1'b0}
    };

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, req_valid, adv_hold;
    logic [20:0] req_addr;
    logic [15:0] req_data;
    logic [1:0]  req_be;
    logic [1:0]  rdy, dn, adv_n, cs_n, we_n, ub_n, lb_n, oe;
    logic [1:0][20:0] maddr;
    logic [1:0][15:0] mdq;

    int n_chk = 0;
    int n_err = 0;

    psw_write_ctrl #(.T_ADDR_SETUP(T_AS), .T_ADV_LOW(T_VP), .T_WE_LOW(T_WP),
        .T_DATA_SETUP(T_DS), .T_DATA_HOLD(T_DH), .T_RECOVER(T_WR), .TERM_CS(1'b0)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .adv_hold(adv_hold),
        .req_ready(rdy[0]), .done(dn[0]), .mem_addr(maddr[0]), .mem_adv_n(adv_n[0]),
        .mem_cs_n(cs_n[0]), .mem_we_n(we_n[0]), .mem_ub_n(ub_n[0]), .mem_lb_n(lb_n[0]),
        .mem_dq_out(mdq[0]), .mem_dq_oe(oe[0]));

    psw_write_ctrl #(.T_ADDR_SETUP(T_AS), .T_ADV_LOW(T_VP), .T_WE_LOW(T_WP),
        .T_DATA_SETUP(T_DS), .T_DATA_HOLD(T_DH), .T_RECOVER(T_WR), .TERM_CS(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .adv_hold(adv_hold),
        .req_ready(rdy[1]), .done(dn[1]), .mem_addr(maddr[1]), .mem_adv_n(adv_n[1]),
        .mem_cs_n(cs_n[1]), .mem_we_n(we_n[1]), .mem_ub_n(ub_n[1]), .mem_lb_n(lb_n[1]),
        .mem_dq_out(mdq[1]), .mem_dq_oe(oe[1]));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int phase_of(input int k);
        if (k <= SU)             return 1;
        if (k <= SU + PL)        return 2;
        if (k <= SU + PL + T_DH) return 3;
        return 4;
    endfunction

    task automatic check_idle(input string tag);
        for (int i = 0; i < 2; i++) begin
            chk($sformatf("%s cs_n u%0d", tag, i), cs_n[i], 1);
            chk($sformatf("%s we_n u%0d", tag, i), we_n[i], 1);
            chk($sformatf("%s ub_n u%0d", tag, i), ub_n[i], 1);
            chk($sformatf("%s lb_n u%0d", tag, i), lb_n[i], 1);
            chk($sformatf("%s adv_n u%0d", tag, i), adv_n[i], 1);
            chk($sformatf("%s oe u%0d", tag, i), oe[i], 0);
            chk($sformatf("%s done u%0d", tag, i), dn[i], 0);
            chk($sformatf("%s ready u%0d", tag, i), rdy[i], 1);
        end
    endtask

    task automatic check_cycle(input int k, input logic [20:0] a, input logic [15:0] d,
                               input logic [1:0] be, input logic hold);
        int p;
        p = phase_of(k);
        for (int i = 0; i < 2; i++) begin
            logic e_cs, e_we, e_ub, e_lb, e_adv, e_oe;
            string tg;
            e_cs  = !(p == 1 || p == 2 || (p == 3 && i == 0));
            e_we  = !(p == 2 || (p == 3 && i == 1));
            e_ub  = !((p == 2 || p == 3) && be[1]);
            e_lb  = !((p == 2 || p == 3) && be[0]);
            e_adv = hold ? 1'b0 : !(k <= T_VP);
            e_oe  = (p == 2 && k > SU + 1) || p == 3;
            tg = (p == 1) ? "R2" : (p == 2) ? "R3" : (p == 4) ? "R10" : (i == 1) ? "R7" : "R6";
            chk($sformatf("%s cs_n u%0d k=%0d", tg, i, k), cs_n[i], e_cs);
            chk($sformatf("%s we_n u%0d k=%0d", tg, i, k), we_n[i], e_we);
            chk($sformatf("R3 ub_n u%0d k=%0d", i, k), ub_n[i], e_ub);
            chk($sformatf("R3 lb_n u%0d k=%0d", i, k), lb_n[i], e_lb);
            chk($sformatf("%s adv_n u%0d k=%0d", hold ? "R9" : "R8", i, k), adv_n[i], e_adv);
            chk($sformatf("R5 oe u%0d k=%0d", i, k), oe[i], e_oe);
            chk($sformatf("R5 addr u%0d k=%0d", i, k), maddr[i], a);
            if (e_oe) chk($sformatf("R5 dq u%0d k=%0d", i, k), mdq[i], d);
            chk($sformatf("R10 done u%0d k=%0d", i, k), dn[i], (k == N));
            chk($sformatf("R1 ready busy u%0d k=%0d", i, k), rdy[i], 0);
        end
    endtask

    task automatic run_write(input logic [40:0] v);
        logic [20:0] a;
        logic [15:0] d;
        logic [1:0]  be;
        logic        hold, poke;
        {a, d, be, hold, poke} = v;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_data = d; req_be = be; adv_hold = hold;
        for (int k = 1; k <= N; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (poke) begin
                    req_addr = ~a; req_data = ~d; req_be = 2'b11; adv_hold = ~hold;
                end else begin
                    req_valid = 1'b0;
                end
            end
            check_cycle(k, a, d, be, hold);
            if (k == N) req_valid = 1'b0;
        end
        @(negedge clk);
        for (int i = 0; i < 2; i++) chk($sformatf("R1 ready after done u%0d", i), rdy[i], 1);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_data = '0; req_be = 2'b00; adv_hold = 1'b0;
        repeat (2) @(negedge clk);
        check_idle("R11 after reset");
        rst = 1'b0;

        for (int v = 0; v < NV; v++) run_write(VECS[v]);

        // R4: both byte enables clear
        @(negedge clk);
        req_valid = 1'b1; req_addr = 21'h012345; req_data = 16'h5A5A; req_be = 2'b00;
        repeat (3) begin
            @(negedge clk);
            check_idle("R4 empty enables");
        end
        req_valid = 1'b0;

        // R11: reset in the middle of the pulse phase
        @(negedge clk);
        req_valid = 1'b1; req_addr = 21'h0F0F0F; req_data = 16'hC3C3; req_be = 2'b11; adv_hold = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (SU + 1) @(negedge clk);
        for (int i = 0; i < 2; i++) chk($sformatf("R3 pre-reset we_n u%0d", i), we_n[i], 0);
        rst = 1'b1;
        @(negedge clk);
        check_idle("R11 mid-cycle reset");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_idle("R11 stays idle");

        run_write({21'h1C_0DE0, 16'h7E7E, 2'b11, 1'b0, 1'b0});

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule